// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block is the mode sequencer of a high-speed CAN transceiver. It reads two host control pins, a standby-release pin and an enable pin, and from them selects one of five modes: normal, listen-only, standby, go-to-sleep and sleep. From the mode it drives the transmitter enable, the receiver select, the regulator-inhibit output and the bus bias / split-termination enable.

Sleep is reached in only two ways. The first is a go-to-sleep request that the host keeps unchanged for a parameterised hold time. The second is a filtered undervoltage, which forces sleep from any mode. A go-to-sleep request is abandoned if a wake flag arrives or if the host changes the pins during the hold. From sleep, a wake flag returns the block to standby and pulls the wake indication low for a fixed number of cycles. The host can also leave sleep by raising the standby-release pin. The wake pattern detector and all analog parts sit outside this block.

Top module: `can_xcvr_mode_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released until a pin change, mode_o reads standby (2), inh_o is 1, tx_en_o, rx_normal_o and bias_en_o are 0, and rxd_wake_n_o is 1.
- R2: Mode codes are normal=0, listen-only=1, standby=2, go-to-sleep=3, sleep=4. Outside sleep and go-to-sleep, the pins (stby_n_i, en_i) select the mode one clock after they are sampled: (1,1) normal, (1,0) listen-only, (0,0) standby, (0,1) go-to-sleep.
- R3: tx_en_o is 1 only in normal. rx_normal_o and bias_en_o are 1 in normal and listen-only, and 0 in all other modes.
- R4: inh_o is 0 in sleep and 1 in every other mode.
- R5: Go-to-sleep with unchanged pins, no wake flag and no undervoltage lasts exactly HOLD_CYC cycles and is followed by sleep. Apart from undervoltage, sleep is entered from no other mode.
- R6: A pin change during go-to-sleep moves the block to the mode of the new pins on the next cycle.
- R7: wake_i during go-to-sleep moves the block to standby on the next cycle.
- R8: wake_i in sleep moves the block to standby on the next cycle. rxd_wake_n_o is 0 for exactly WAKE_PULSE_CYC cycles, starting with that first standby cycle.
- R9: stby_n_i high in sleep moves the block to the mode of the pins on the next cycle, and rxd_wake_n_o stays 1.
- R10: uv_i high on UV_FILT_CYC consecutive clock edges puts the block in sleep from any mode. A shorter burst has no effect on any output.
- R11: While uv_i stays high after a trip, the block stays in sleep and ignores wake_i and the pins.
- R12: In sleep, with stby_n_i low, no wake flag and no undervoltage, the mode stays sleep whatever en_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| stby_n_i | input | 1 | Host standby-release pin |
| en_i | input | 1 | Host enable pin |
| wake_i | input | 1 | Wake flag from the wake detector |
| uv_i | input | 1 | Raw undervoltage indication (supply or I/O rail) |
| mode_o | output | 3 | Current mode code |
| tx_en_o | output | 1 | Transmitter enable |
| rx_normal_o | output | 1 | 1 selects the full receiver, 0 the low-power monitor |
| inh_o | output | 1 | 1 drives the inhibit pin high, 0 releases it |
| bias_en_o | output | 1 | Bus bias and split-termination enable |
| rxd_wake_n_o | output | 1 | Active-low wake indication toward the receive data pin |

## Verification
A wrong mode register shows on mode_o and on the drive outputs in the very next cycle. A bench model steps alongside the design and compares every output in every cycle. A hold counter that is off by one moves the first sleep cycle and the fall of inh_o by one cycle. A wrong undervoltage filter shifts the forced sleep, or lets short bursts through, and both show up directly in mode_o. A broken wake pulse counter changes the width of the low period on rxd_wake_n_o, and that width is measured in the cycles that follow the wake.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL  = 3'd0,
    MODE_LISTEN  = 3'd1,
    MODE_STANDBY = 3'd2,
    MODE_GTS     = 3'd3,
    MODE_SLEEP   = 3'd4
  } can_mode_e;

  typedef struct packed {
    logic tx_en;
    logic rx_normal;
    logic inh;
    logic bias;
  } can_drive_t;

  function automatic can_mode_e pin_mode(input logic stby_n, input logic en);
    if (stby_n) return en ? MODE_NORMAL : MODE_LISTEN;
    return en ? MODE_GTS : MODE_STANDBY;
  endfunction

endpackage

// File: rtl/can_uv_filter.sv
module can_uv_filter #(
  parameter int unsigned FILT_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  output logic trip_o
);
  localparam int unsigned CW  = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!uv_i)     cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  // trips on the FILT_CYC-th consecutive high sample
  assign trip_o = uv_i && (cnt_q >= LIM);

  generate
    if (FILT_CYC > 1) begin : g_chk
      assert_uv_history_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trip_o |-> $past(uv_i));
    end
  endgenerate
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stby_n_i,
  input  logic      en_i,
  input  logic      wake_i,
  input  logic      uv_trip_i,
  output can_mode_e mode_o,
  output logic      wake_evt_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  can_mode_e     state_q, state_d, pin_sel;
  logic [HW-1:0] hold_q, hold_d;

  assign pin_sel = pin_mode(stby_n_i, en_i);

  always_comb begin
    state_d    = pin_sel;
    wake_evt_o = 1'b0;
    if (uv_trip_i) begin
      state_d = MODE_SLEEP;
    end else begin
      unique case (state_q)
        MODE_SLEEP: begin
          if (wake_i) begin
            state_d    = MODE_STANDBY;
            wake_evt_o = 1'b1;
          end else if (!stby_n_i) begin
            state_d = MODE_SLEEP;
          end
        end
        MODE_GTS: begin
          if (wake_i)                  state_d = MODE_STANDBY;
          else if (pin_sel != MODE_GTS) state_d = pin_sel;
          else if (hold_q == HOLD_LAST) state_d = MODE_SLEEP;
          else                          state_d = MODE_GTS;
        end
        default: state_d = pin_sel;
      endcase
    end
  end

  assign hold_d = (state_q == MODE_GTS && state_d == MODE_GTS) ? hold_q + 1'b1 : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_STANDBY;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  assign mode_o = state_q;

  assert_sleep_via_gts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != MODE_GTS && state_q != MODE_SLEEP && !uv_trip_i) |=> state_q != MODE_SLEEP);
  assert_hold_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_GTS) |-> (hold_q <= HOLD_LAST));
  assert_wake_standby_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_SLEEP && wake_i && !uv_trip_i) |=> state_q == MODE_STANDBY);
  assert_uv_forces_sleep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_trip_i |=> state_q == MODE_SLEEP);
endmodule

// File: rtl/can_mode_drive.sv
module can_mode_drive
  import can_mode_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  can_mode_e  mode_i,
  input  logic       wake_evt_i,
  output can_drive_t drive_o,
  output logic       rxd_wake_n_o
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] pulse_q;

  always_comb begin
    drive_o = '{tx_en: 1'b0, rx_normal: 1'b0, inh: 1'b1, bias: 1'b0};
    unique case (mode_i)
      MODE_NORMAL: drive_o = '{tx_en: 1'b1, rx_normal: 1'b1, inh: 1'b1, bias: 1'b1};
      MODE_LISTEN: drive_o = '{tx_en: 1'b0, rx_normal: 1'b1, inh: 1'b1, bias: 1'b1};
      MODE_SLEEP:  drive_o = '{tx_en: 1'b0, rx_normal: 1'b0, inh: 1'b0, bias: 1'b0};
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pulse_q <= '0;
    else if (wake_evt_i)   pulse_q <= PW'(PULSE_CYC);
    else if (pulse_q != 0) pulse_q <= pulse_q - 1'b1;
  end

  assign rxd_wake_n_o = (pulse_q == '0);

  assert_pulse_origin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rxd_wake_n_o) |-> $past(wake_evt_i));
endmodule

// File: rtl/can_xcvr_mode_ctrl.sv
module can_xcvr_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int unsigned HOLD_CYC       = 16,
  parameter int unsigned UV_FILT_CYC    = 8,
  parameter int unsigned WAKE_PULSE_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_n_i,
  input  logic       en_i,
  input  logic       wake_i,
  input  logic       uv_i,
  output logic [2:0] mode_o,
  output logic       tx_en_o,
  output logic       rx_normal_o,
  output logic       inh_o,
  output logic       bias_en_o,
  output logic       rxd_wake_n_o
);
  logic       uv_trip, wake_evt;
  can_mode_e  mode;
  can_drive_t drv;

  can_uv_filter #(.FILT_CYC(UV_FILT_CYC)) u_uv (
    .clk_i(clk_i), .rst_ni(rst_ni), .uv_i(uv_i), .trip_o(uv_trip)
  );

  can_mode_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .stby_n_i(stby_n_i), .en_i(en_i),
    .wake_i(wake_i), .uv_trip_i(uv_trip), .mode_o(mode), .wake_evt_o(wake_evt)
  );

  can_mode_drive #(.PULSE_CYC(WAKE_PULSE_CYC)) u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .wake_evt_i(wake_evt),
    .drive_o(drv), .rxd_wake_n_o(rxd_wake_n_o)
  );

  assign mode_o      = mode;
  assign tx_en_o     = drv.tx_en;
  assign rx_normal_o = drv.rx_normal;
  assign inh_o       = drv.inh;
  assign bias_en_o   = drv.bias;

  assert_pulse_in_standby_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rxd_wake_n_o) |-> mode_o == MODE_STANDBY);
  assert_inh_follows_sleep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(uv_trip) || $past(mode) == MODE_GTS || $past(mode) == MODE_SLEEP) || inh_o);
endmodule

// File: tb/sim_can_xcvr_mode_ctrl.sv
module sim_can_xcvr_mode_ctrl;
  localparam int HOLD = 16;
  localparam int FILT = 8;
  localparam int PULS = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic stby_n = 1'b0, en = 1'b0, wake = 1'b0, uv = 1'b0;
  logic [2:0] mode;
  logic tx_en, rx_normal, inh, bias_en, rxd_n;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  can_xcvr_mode_ctrl #(.HOLD_CYC(HOLD), .UV_FILT_CYC(FILT), .WAKE_PULSE_CYC(PULS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .stby_n_i(stby_n), .en_i(en), .wake_i(wake), .uv_i(uv),
    .mode_o(mode), .tx_en_o(tx_en), .rx_normal_o(rx_normal), .inh_o(inh),
    .bias_en_o(bias_en), .rxd_wake_n_o(rxd_n)
  );

  always #10 clk = ~clk;

  function automatic int dec(input logic s, input logic e);
    if (s) return e ? 0 : 1;
    return e ? 3 : 2;
  endfunction

  // {tx, rx, inh, bias} expected per mode (R3, R4)
  function automatic logic [3:0] exp_drv(input int m);
    case (m)
      0: return 4'b1111;
      1: return 4'b0111;
      4: return 4'b0000;
      default: return 4'b0010;
    endcase
  endfunction

  int m_mode = 2, m_hold = 0, m_uvc = 0, m_pulse = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode <= 2; m_hold <= 0; m_uvc <= 0; m_pulse <= 0;
    end else begin
      int nxt;
      bit trip, wev;
      trip = uv && (m_uvc >= FILT - 1);
      wev  = 0;
      nxt  = dec(stby_n, en);
      if (trip) nxt = 4;
      else if (m_mode == 4) begin
        if (wake) begin nxt = 2; wev = 1; end
        else if (!stby_n) nxt = 4;
      end else if (m_mode == 3) begin
        if (wake) nxt = 2;
        else if (dec(stby_n, en) != 3) nxt = dec(stby_n, en);
        else if (m_hold == HOLD - 1) nxt = 4;
        else nxt = 3;
      end
      m_uvc   <= !uv ? 0 : (m_uvc < FILT - 1 ? m_uvc + 1 : m_uvc);
      m_hold  <= (m_mode == 3 && nxt == 3) ? m_hold + 1 : 0;
      m_pulse <= wev ? PULS : (m_pulse > 0 ? m_pulse - 1 : 0);
      m_mode  <= nxt;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] d;
    d = exp_drv(m_mode);
    chk(cur_req, "mode", int'(mode), m_mode);
    chk("R3", "tx_en", int'(tx_en), int'(d[3]));
    chk("R3", "rx_normal", int'(rx_normal), int'(d[2]));
    chk("R4", "inh", int'(inh), int'(d[1]));
    chk("R3", "bias_en", int'(bias_en), int'(d[0]));
    chk("R8", "rxd_wake_n", int'(rxd_n), (m_pulse == 0) ? 1 : 0);
  end

  task automatic drive(input logic s, input logic e, input logic w, input logic u);
    @(posedge clk); #2;
    stby_n = s; en = e; wake = w; uv = u;
  endtask

  task automatic hold_pins(input logic s, input logic e, input int n);
    for (int i = 0; i < n; i++) drive(s, e, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd7331);
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #3 rst_ni = 1'b1;
    hold_pins(0, 0, 3);
    cur_req = "R2";
    hold_pins(1, 1, 3); hold_pins(1, 0, 3); hold_pins(0, 0, 3);
    cur_req = "R5";
    hold_pins(0, 1, HOLD + 4);
    cur_req = "R12";
    hold_pins(0, 0, 4); hold_pins(0, 1, 3);
    cur_req = "R9";
    hold_pins(1, 1, 3);
    cur_req = "R6";
    hold_pins(0, 1, 5); hold_pins(1, 0, 3);
    cur_req = "R7";
    hold_pins(0, 1, 5); drive(0, 1, 1, 0); hold_pins(0, 0, 3);
    cur_req = "R8";
    hold_pins(0, 1, HOLD + 3); hold_pins(0, 0, 2);
    drive(0, 0, 1, 0); hold_pins(0, 0, PULS + 4);
    cur_req = "R10";
    hold_pins(1, 1, 2);
    for (int i = 0; i < FILT - 1; i++) drive(1, 1, 0, 1);
    hold_pins(1, 1, 3);
    for (int i = 0; i < FILT + 3; i++) drive(1, 1, 0, 1);
    cur_req = "R11";
    drive(1, 1, 1, 1); drive(0, 0, 1, 1); drive(1, 0, 0, 1);
    hold_pins(1, 1, 3);
    cur_req = "R3";
    for (int seg = 0; seg < 1500; seg++) begin
      logic s, e;
      int len;
      s = 1'($urandom); e = 1'($urandom);
      len = 1 + int'($urandom % (HOLD + 8));
      for (int i = 0; i < len; i++) begin
        logic w, u;
        w = ($urandom % 40) == 0;
        u = ($urandom % 100) < ((seg % 7 == 0) ? 90 : 2);
        drive(s, e, w, u);
      end
    end
    hold_pins(0, 0, 3);
    finish_run();
  end
endmodule